// File: doc/BRIEF.md
# SPI Master with Per-Select Transfer Profiles

This block is a serial peripheral bus master with four chip-select outputs. Each select has its own transfer profile, and that profile fixes the clock idle level, which clock edge samples the data, the word length, the clock divider, a lead time from select assertion to the first clock edge, a gap after the last edge, and whether the select stays asserted once the word is done. Profiles are written through a small write port. The write strobe, the slot index and all profile fields are presented in one cycle.

A transfer is requested with a one-cycle start pulse that carries a data word and a device number. The profile slot used is given by the low two bits of the device number. The master shifts the word out most significant bit first and shifts the reply in at the same time. It then presents the received word right-justified and raises a one-cycle done pulse. In direct mode one of the four select lines goes low. In decoded mode the four lines carry the device number as a binary code for an external decoder. Code 15 means that no device is selected, which leaves up to 15 devices addressable. A mode-fault input can abort a transfer and lock out the master until the host clears the fault.

Top module: `spi_prof_master`

## Requirements
- R1: After reset, cs_n is 4'b1111, sck is 0, and busy, done and fault are 0. Every profile slot then holds idle level 0, sample-on-leading-edge, 8 bits, divider 1, lead 0, gap 0 and keep off.
- R2: A write with cfg_we high updates only the slot given by cfg_idx. Each transfer uses the slot selected by dev[1:0], so slots written earlier keep their own settings.
- R3: The word length is cfg_bits limited to the range 8..16. The low `len` bits of tx_data are sent on mosi, most significant first. rx_data holds the `len` received bits right-justified with the upper bits zero, and it is valid from the done pulse until the next accepted start.
- R4: sck takes the profile's idle level (cfg_cpol) on the cycle after the start is accepted and toggles exactly 2·len times. With cfg_cpha = 0 the data is captured on the edges that leave the idle level (leading edges). With cfg_cpha = 1 it is captured on the edges that return to it. mosi changes only on the other edges.
- R5: If a start is accepted at clock edge 0, done is high for one cycle after edge lead+1+2·len·div, and busy drops gap+1 edges after that. A start that arrives while busy is high is ignored.
- R6: Every sck half-period lasts div clock cycles. A divider value of 0 acts as 1, which gives an sck frequency of half the clock.
- R7: In direct mode (decode_en = 0) the start edge drives cs_n[dev[1:0]] low and all other lines high, so at most one line is ever low.
- R8: In decoded mode (decode_en = 1) cs_n carries dev while the select is active and 4'b1111 otherwise. A start with dev = 15 is ignored.
- R9: With keep set in the profile, the select stays asserted after busy falls. A following transfer to the same dev keeps the select asserted without a break. A start to a different dev moves the select to the new device on its start edge. With keep clear, the select is released on the edge where busy falls.
- R10: With fault_en high, fault_in high at a clock edge while busy aborts the transfer on that edge. fault goes to 1, busy to 0, cs_n to 4'b1111, sck to the idle level, and no done is produced. While fault is 1, starts are ignored. fault_in has no effect when fault_en is low or while the master is idle.
- R11: fault stays set until a fault_clr pulse, which clears it on the next edge and takes priority over a new fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Profile write strobe |
| cfg_idx | input | 2 | Profile slot to write |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| cfg_bits | input | 5 | Word length, limited to 8..16 |
| cfg_div | input | 8 | Clock cycles per sck half-period (0 acts as 1) |
| cfg_lead | input | 8 | Extra cycles between select assertion and first sck edge |
| cfg_gap | input | 8 | Extra cycles after the last sck edge before idle |
| cfg_keep | input | 1 | Keep the select asserted after the transfer |
| decode_en | input | 1 | Drive cs_n as a binary device code |
| fault_en | input | 1 | Enable mode-fault detection |
| fault_in | input | 1 | Mode-fault input, active high |
| fault_clr | input | 1 | Clear the fault flag |
| start | input | 1 | Transfer request pulse |
| dev | input | 4 | Device number, low two bits select the profile |
| tx_data | input | 16 | Word to send, right-justified |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 4 | Select lines, active low or binary code |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | 16 | Received word, right-justified |
| fault | output | 1 | Mode-fault flag |

## Verification
Each result of this block has a fixed due edge. cs_n and the sck idle level change on the edge that accepts the start, and done follows lead+1+2·len·div edges after it. busy falls gap+1 edges after done, and a fault abort shows on the edge that sees fault_in. The bench drives and samples on the falling clock edge and counts falling edges from the start pulse. It compares the count at which done and the fall of busy appear with these formulas, where the length and divider come from the limited profile values. During the transfer it also records every sck toggle at the falling edge. From that record it checks the half-period spacing and rebuilds the serial word from mosi at the capture edges that the idle level and capture setting call for.

// File: rtl/spi_prof_pkg.sv
package spi_prof_pkg;

    localparam int NSEL     = 4;
    localparam int SEL_W    = $clog2(NSEL);
    localparam int DEV_W    = NSEL;
    localparam int DW       = 16;
    localparam int LEN_W    = $clog2(DW + 1);
    localparam int HALF_W   = LEN_W + 1;
    localparam int DIV_W    = 8;
    localparam int DLY_W    = 8;
    localparam int CNT_W    = (DIV_W > DLY_W) ? DIV_W : DLY_W;

    localparam logic [LEN_W-1:0] MIN_BITS = LEN_W'(8);
    localparam logic [LEN_W-1:0] MAX_BITS = LEN_W'(DW);

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic [LEN_W-1:0] bits;
        logic [DIV_W-1:0] div;
        logic [DLY_W-1:0] lead;
        logic [DLY_W-1:0] gap;
        logic             keep;
    } prof_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP
    } st_t;

    localparam prof_t PROF_RST = '{
        cpol: 1'b0, cpha: 1'b0, bits: MIN_BITS,
        div: DIV_W'(1), lead: '0, gap: '0, keep: 1'b0
    };

    function automatic logic [LEN_W-1:0] clamp_bits(input logic [LEN_W-1:0] b);
        if (b < MIN_BITS) return MIN_BITS;
        if (b > MAX_BITS) return MAX_BITS;
        return b;
    endfunction

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

endpackage

// File: rtl/spi_prof_regs.sv
module spi_prof_regs
    import spi_prof_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wr_idx,
    input  prof_t            wr_prof,
    input  logic [SEL_W-1:0] rd_idx,
    output prof_t            rd_prof
);

    prof_t slot [NSEL];

    for (genvar g = 0; g < NSEL; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[g] <= PROF_RST;
            else if (we && wr_idx == SEL_W'(g))
                slot[g] <= wr_prof;
        end
    end

    assign rd_prof = slot[rd_idx];

endmodule

// File: rtl/spi_prof_shift.sv
module spi_prof_shift
    import spi_prof_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             ld_cpol,
    input  logic             ld_cpha,
    input  logic [LEN_W-1:0] ld_bits,
    input  logic [DW-1:0]    ld_data,
    input  logic             tick,
    input  logic             abort,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             last_half,
    output logic [DW-1:0]    rx_word
);

    logic [DW:0]       sh;
    logic [DW-1:0]     rx;
    logic [DW-1:0]     left_just;
    logic [HALF_W-1:0] half;
    logic [LEN_W-1:0]  bits_q;
    logic              cpol_q;
    logic              cpha_q;
    logic              sck_q;

    // Word moved to the top of the register so the first bit is always sh[DW].
    always_comb left_just = ld_data << (LEN_W'(DW) - ld_bits);

    assign last_half = (half == (({1'b0, bits_q}) << 1) - HALF_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            rx     <= '0;
            half   <= '0;
            bits_q <= MIN_BITS;
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            sck_q  <= 1'b0;
        end else if (abort) begin
            sck_q <= cpol_q;
            half  <= '0;
        end else if (load) begin
            sck_q  <= ld_cpol;
            cpol_q <= ld_cpol;
            cpha_q <= ld_cpha;
            bits_q <= ld_bits;
            half   <= '0;
            rx     <= '0;
            // Trailing-capture mode shifts before its first bit, so preload one place lower.
            sh     <= ld_cpha ? {1'b0, left_just} : {left_just, 1'b0};
        end else if (tick) begin
            sck_q <= ~sck_q;
            half  <= half + HALF_W'(1);
            if (half[0] == cpha_q)
                rx <= {rx[DW-2:0], miso};
            else
                sh <= {sh[DW-1:0], 1'b0};
        end
    end

    assign sck     = sck_q;
    assign mosi    = sh[DW];
    assign rx_word = rx;

endmodule

// File: rtl/spi_prof_ctrl.sv
module spi_prof_ctrl
    import spi_prof_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DEV_W-1:0] dev,
    input  logic             decode_en,
    input  logic             fault_en,
    input  logic             fault_in,
    input  logic             fault_clr,
    input  logic [DIV_W-1:0] p_div,
    input  logic [DLY_W-1:0] p_lead,
    input  logic [DLY_W-1:0] p_gap,
    input  logic             p_keep,
    input  logic             last_half,
    output logic             load,
    output logic             tick,
    output logic             abort,
    output logic [DEV_W-1:0] cs_n,
    output logic             busy,
    output logic             done,
    output logic             fault
);

    st_t              st;
    logic [CNT_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic [DLY_W-1:0] gap_q;
    logic             keep_q;
    logic [DEV_W-1:0] cs_dev;
    logic             cs_act;
    logic             fault_q;
    logic             done_q;
    logic             dev_ok;
    logic             cnt_zero;

    assign dev_ok   = !(decode_en && dev == '1);
    assign load     = (st == ST_IDLE) && start && !fault_q && dev_ok;
    assign abort    = fault_en && fault_in && (st != ST_IDLE);
    assign cnt_zero = (cnt == '0);
    assign tick     = (st == ST_SHIFT) && cnt_zero && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            div_q   <= DIV_W'(1);
            gap_q   <= '0;
            keep_q  <= 1'b0;
            cs_dev  <= '0;
            cs_act  <= 1'b0;
            fault_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort)     fault_q <= 1'b1;
            if (fault_clr) fault_q <= 1'b0;

            if (abort) begin
                st     <= ST_IDLE;
                cs_act <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: if (load) begin
                        st     <= ST_LEAD;
                        cnt    <= CNT_W'(p_lead);
                        div_q  <= eff_div(p_div);
                        gap_q  <= p_gap;
                        keep_q <= p_keep;
                        cs_dev <= dev;
                        cs_act <= 1'b1;
                    end
                    ST_LEAD: begin
                        if (cnt_zero) begin
                            st  <= ST_SHIFT;
                            cnt <= CNT_W'(div_q - DIV_W'(1));
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    ST_SHIFT: begin
                        if (cnt_zero) begin
                            if (last_half) begin
                                st     <= ST_GAP;
                                cnt    <= CNT_W'(gap_q);
                                done_q <= 1'b1;
                            end else begin
                                cnt <= CNT_W'(div_q - DIV_W'(1));
                            end
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    ST_GAP: begin
                        if (cnt_zero) begin
                            st <= ST_IDLE;
                            if (!keep_q) cs_act <= 1'b0;
                        end else begin
                            cnt <= cnt - CNT_W'(1);
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    for (genvar i = 0; i < DEV_W; i++) begin : g_cs
        assign cs_n[i] = decode_en ? (cs_act ? cs_dev[i] : 1'b1)
                                   : !(cs_act && cs_dev[SEL_W-1:0] == SEL_W'(i));
    end

    assign busy  = (st != ST_IDLE);
    assign done  = done_q;
    assign fault = fault_q;

endmodule

// File: rtl/spi_prof_master.sv
module spi_prof_master
    import spi_prof_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_idx,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic [LEN_W-1:0] cfg_bits,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [DLY_W-1:0] cfg_lead,
    input  logic [DLY_W-1:0] cfg_gap,
    input  logic             cfg_keep,
    input  logic             decode_en,
    input  logic             fault_en,
    input  logic             fault_in,
    input  logic             fault_clr,
    input  logic             start,
    input  logic [DEV_W-1:0] dev,
    input  logic [DW-1:0]    tx_data,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic [DEV_W-1:0] cs_n,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rx_data,
    output logic             fault
);

    prof_t wr_prof;
    prof_t cur;
    logic  load;
    logic  tick;
    logic  abort;
    logic  last_half;

    assign wr_prof = '{
        cpol: cfg_cpol, cpha: cfg_cpha, bits: cfg_bits,
        div: cfg_div, lead: cfg_lead, gap: cfg_gap, keep: cfg_keep
    };

    spi_prof_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_prof (wr_prof),
        .rd_idx  (dev[SEL_W-1:0]),
        .rd_prof (cur)
    );

    spi_prof_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dev       (dev),
        .decode_en (decode_en),
        .fault_en  (fault_en),
        .fault_in  (fault_in),
        .fault_clr (fault_clr),
        .p_div     (cur.div),
        .p_lead    (cur.lead),
        .p_gap     (cur.gap),
        .p_keep    (cur.keep),
        .last_half (last_half),
        .load      (load),
        .tick      (tick),
        .abort     (abort),
        .cs_n      (cs_n),
        .busy      (busy),
        .done      (done),
        .fault     (fault)
    );

    spi_prof_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .ld_cpol   (cur.cpol),
        .ld_cpha   (cur.cpha),
        .ld_bits   (clamp_bits(cur.bits)),
        .ld_data   (tx_data),
        .tick      (tick),
        .abort     (abort),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .last_half (last_half),
        .rx_word   (rx_data)
    );

endmodule

// File: rtl/spi_prof_checker.sv
module spi_prof_checker
    import spi_prof_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             decode_en,
    input logic             fault_clr,
    input logic             sck,
    input logic [DEV_W-1:0] cs_n,
    input logic             busy,
    input logic             done,
    input logic             fault
);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_in_xfer_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    p_sck_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (busy || $stable(sck)));

    p_cs_single_r7: assert property (@(posedge clk) disable iff (rst)
        !decode_en |-> ($countones(~cs_n) <= 1));

    p_cs_code_r8: assert property (@(posedge clk) disable iff (rst)
        (decode_en && busy) |-> (cs_n != '1));

    p_fault_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (fault && !$past(fault)) |-> (!busy && cs_n == '1));

    p_fault_no_done_r10: assert property (@(posedge clk) disable iff (rst)
        fault |-> !done);

    p_fault_clear_r11: assert property (@(posedge clk) disable iff (rst)
        fault_clr |=> !fault);

endmodule

bind spi_prof_master spi_prof_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .decode_en (decode_en),
    .fault_clr (fault_clr),
    .sck       (sck),
    .cs_n      (cs_n),
    .busy      (busy),
    .done      (done),
    .fault     (fault)
);

// File: tb/tb_spi_prof_master.sv
module tb_spi_prof_master;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 7;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [3:0]  dev;
        logic [15:0] data;
        logic        cpol;
        logic        cpha;
        logic [4:0]  bits;
        logic [7:0]  div;
        logic [7:0]  lead;
        logic [7:0]  gap;
        logic        inv;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{4'd0, 16'h00A5, 1'b0, 1'b0, 5'd8,  8'd1, 8'd0, 8'd0, 1'b0},
        '{4'd1, 16'h003C, 1'b0, 1'b1, 5'd8,  8'd2, 8'd1, 8'd2, 1'b1},
        '{4'd2, 16'h1234, 1'b1, 1'b0, 5'd12, 8'd3, 8'd3, 8'd0, 1'b0},
        '{4'd3, 16'hBEEF, 1'b1, 1'b1, 5'd16, 8'd1, 8'd2, 8'd1, 1'b1},
        '{4'd0, 16'h0081, 1'b0, 1'b1, 5'd4,  8'd0, 8'd0, 8'd1, 1'b0},
        '{4'd1, 16'hCAFE, 1'b1, 1'b0, 5'd20, 8'd4, 8'd0, 8'd3, 1'b0},
        '{4'd2, 16'h0155, 1'b0, 1'b0, 5'd9,  8'd2, 8'd5, 8'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic [4:0]  cfg_bits = 5'd8;
    logic [7:0]  cfg_div = 8'd1;
    logic [7:0]  cfg_lead = '0;
    logic [7:0]  cfg_gap = '0;
    logic        cfg_keep = 1'b0;
    logic        decode_en = 1'b0;
    logic        fault_en = 1'b0;
    logic        fault_in = 1'b0;
    logic        fault_clr = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  dev = '0;
    logic [15:0] tx_data = '0;
    logic        inv_r = 1'b0;
    logic        miso;
    logic        sck;
    logic        mosi;
    logic [3:0]  cs_n;
    logic        busy;
    logic        done;
    logic [15:0] rx_data;
    logic        fault;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    assign miso = mosi ^ inv_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_prof_master dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_bits(cfg_bits),
        .cfg_div(cfg_div), .cfg_lead(cfg_lead), .cfg_gap(cfg_gap),
        .cfg_keep(cfg_keep), .decode_en(decode_en), .fault_en(fault_en),
        .fault_in(fault_in), .fault_clr(fault_clr), .start(start), .dev(dev),
        .tx_data(tx_data), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .busy(busy), .done(done), .rx_data(rx_data), .fault(fault)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic prog(input logic [1:0] idx, input logic cp, input logic ch,
                        input logic [4:0] b, input logic [7:0] dv,
                        input logic [7:0] ld, input logic [7:0] gp, input logic kp);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_cpol = cp; cfg_cpha = ch;
        cfg_bits = b; cfg_div = dv; cfg_lead = ld; cfg_gap = gp; cfg_keep = kp;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start(input logic [3:0] d, input logic [15:0] data);
        @(negedge clk);
        start = 1'b1; dev = d; tx_data = data;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Full transfer with timing, edge spacing, serial word and received word checks.
    task automatic run_xfer(input logic [3:0] d, input logic [15:0] data,
                            input logic cp, input logic ch, input int eb,
                            input int ed, input int ld, input int gp, input logic iv);
        int n, m, edges, since, bad_gap;
        logic prev;
        logic [15:0] mon, mask, exp_rx, exp_cs;
        inv_r = iv;
        mask = 16'((32'd1 << eb) - 1);
        exp_rx = (iv ? ~data : data) & mask;
        exp_cs = decode_en ? {12'd0, d} : {12'd0, ~(4'b0001 << d[1:0])};
        pulse_start(d, data);
        n = 1;
        if (decode_en)
            chk(cs_n == exp_cs[3:0], "R8", "decoded select code", cs_n, exp_cs[3:0]);
        else
            chk(cs_n == exp_cs[3:0], "R7", "direct select line", cs_n, exp_cs[3:0]);
        chk(sck == cp, "R4", "sck idle level at start", sck, cp);
        prev = sck; edges = 0; since = 0; bad_gap = 0; mon = '0;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++; since++;
            if (sck != prev) begin
                edges++;
                if (edges > 1 && since != ed) bad_gap++;
                since = 0;
                if ((sck != cp) != ch) mon = {mon[14:0], mosi};
                prev = sck;
            end
        end
        chk(n == ld + 2 + 2*eb*ed, "R5", "edges to done", n, ld + 2 + 2*eb*ed);
        chk(edges == 2*eb, "R4", "sck toggles", edges, 2*eb);
        chk(bad_gap == 0, "R6", "half-period mismatches", bad_gap, 0);
        chk(mon == (data & mask), "R3", "serial word on mosi", mon, data & mask);
        chk(rx_data == exp_rx, "R3", "received word", rx_data, exp_rx);
        m = 0;
        while (busy && m < 4000) begin
            @(negedge clk);
            m++;
        end
        chk(m == gp + 1, "R5", "edges from done to idle", m, gp + 1);
        chk(sck == cp, "R4", "sck back at idle level", sck, cp);
    endtask

    function automatic int clampb(input int b);
        return (b < 8) ? 8 : (b > 16) ? 16 : b;
    endfunction

    function automatic int effd(input int dv);
        return (dv == 0) ? 1 : dv;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(cs_n == 4'hF, "R1", "cs_n after reset", cs_n, 4'hF);
        chk(sck == 1'b0, "R1", "sck after reset", sck, 0);
        chk({busy, done, fault} == 3'b000, "R1", "busy/done/fault after reset",
            {busy, done, fault}, 0);
        // R1: default profile is 8 bits, divider 1, no lead/gap
        run_xfer(4'd0, 16'h005A, 1'b0, 1'b0, 8, 1, 0, 0, 1'b0);

        // R2: slots 0..3 written up front, then used without rewrite
        for (int i = 0; i < 4; i++)
            prog(VECS[i].dev[1:0], VECS[i].cpol, VECS[i].cpha, VECS[i].bits,
                 VECS[i].div, VECS[i].lead, VECS[i].gap, 1'b0);
        for (int i = 0; i < NVEC; i++) begin
            if (i >= 4)
                prog(VECS[i].dev[1:0], VECS[i].cpol, VECS[i].cpha, VECS[i].bits,
                     VECS[i].div, VECS[i].lead, VECS[i].gap, 1'b0);
            run_xfer(VECS[i].dev, VECS[i].data, VECS[i].cpol, VECS[i].cpha,
                     clampb(int'(VECS[i].bits)), effd(int'(VECS[i].div)),
                     int'(VECS[i].lead), int'(VECS[i].gap), VECS[i].inv);
            chk(cs_n == 4'hF, "R9", "select released with keep off", cs_n, 4'hF);
        end

        // R9: keep-active on slot 1
        prog(2'd1, 1'b0, 1'b0, 5'd8, 8'd1, 8'd0, 8'd1, 1'b1);
        prog(2'd2, 1'b0, 1'b0, 5'd8, 8'd1, 8'd0, 8'd0, 1'b0);
        run_xfer(4'd1, 16'h0011, 1'b0, 1'b0, 8, 1, 0, 1, 1'b0);
        chk(cs_n == 4'b1101, "R9", "select held after keep transfer", cs_n, 4'b1101);
        begin
            int breaks;
            breaks = 0;
            @(negedge clk);
            start = 1'b1; dev = 4'd1; tx_data = 16'h0022;
            @(negedge clk);
            start = 1'b0;
            if (cs_n != 4'b1101) breaks++;
            while (busy) begin
                @(negedge clk);
                if (cs_n != 4'b1101) breaks++;
            end
            chk(breaks == 0, "R9", "select gaps on same-device repeat", breaks, 0);
        end
        pulse_start(4'd2, 16'h0033);
        chk(cs_n == 4'b1011, "R9", "select moved to new device", cs_n, 4'b1011);
        while (busy) @(negedge clk);
        chk(cs_n == 4'hF, "R9", "select released after keep-off transfer", cs_n, 4'hF);

        // R8: decoded select
        prog(2'd1, 1'b1, 1'b1, 5'd10, 8'd2, 8'd1, 8'd0, 1'b0);
        decode_en = 1'b1;
        run_xfer(4'd9, 16'h02C3, 1'b1, 1'b1, 10, 2, 1, 0, 1'b0);
        chk(cs_n == 4'hF, "R8", "no-device code after decoded transfer", cs_n, 4'hF);
        pulse_start(4'd15, 16'h00FF);
        @(negedge clk);
        chk(busy == 1'b0 && cs_n == 4'hF, "R8", "device 15 start ignored",
            {busy, cs_n}, 5'h0F);
        decode_en = 1'b0;

        // R10: fault ignored when detection is off
        prog(2'd3, 1'b1, 1'b0, 5'd16, 8'd4, 8'd0, 8'd0, 1'b0);
        pulse_start(4'd3, 16'hA5A5);
        repeat (5) @(negedge clk);
        fault_in = 1'b1;
        @(negedge clk);
        fault_in = 1'b0;
        chk(fault == 1'b0 && busy == 1'b1, "R10", "fault_in with detection off",
            {fault, busy}, 2'b01);
        while (busy) @(negedge clk);
        chk(rx_data == 16'hA5A5, "R10", "transfer completes with detection off",
            rx_data, 16'hA5A5);

        // R10: fault while idle has no effect
        fault_en = 1'b1;
        @(negedge clk);
        fault_in = 1'b1;
        @(negedge clk);
        fault_in = 1'b0;
        @(negedge clk);
        chk(fault == 1'b0, "R10", "fault_in while idle", fault, 0);

        // R10: abort mid-transfer
        begin
            int dones;
            dones = 0;
            pulse_start(4'd3, 16'h5A5A);
            repeat (10) begin
                @(negedge clk);
                if (done) dones++;
            end
            fault_in = 1'b1;
            @(negedge clk);
            fault_in = 1'b0;
            chk(fault == 1'b1, "R10", "fault flag set", fault, 1);
            chk(busy == 1'b0 && cs_n == 4'hF, "R10", "abort releases select",
                {busy, cs_n}, 5'h0F);
            chk(sck == 1'b1, "R10", "sck returns to idle on abort", sck, 1);
            repeat (150) begin
                @(negedge clk);
                if (done) dones++;
            end
            chk(dones == 0, "R10", "no done after abort", dones, 0);
        end
        pulse_start(4'd0, 16'h0077);
        @(negedge clk);
        chk(busy == 1'b0 && cs_n == 4'hF, "R10", "start ignored while faulted",
            {busy, cs_n}, 5'h0F);
        chk(fault == 1'b1, "R11", "fault stays set without clear", fault, 1);

        // R11: clear, then normal operation resumes
        @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk(fault == 1'b0, "R11", "fault cleared", fault, 0);
        fault_en = 1'b0;
        run_xfer(4'd0, 16'h0099, VECS[4].cpol, VECS[4].cpha, 8, 1, 0, 1, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule